// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It observes host write cycles on the device bus and recognises the unlock-then-command sequences that start a byte program, a whole-chip erase or a single-sector erase. It also recognises the single-write commands that pause an erase, restart it, enter identification mode and drop back to plain reads. Each accepted operation produces a one-clock strobe. The strobe carries the captured target address and data byte, or the sector number, so an array controller further down can act on it.

A write cycle is the interval during which both active-low enables are low. The address is taken in the first clock of that interval. The data byte is taken in the last clock of it. The decoder keeps the device mode: plain array reading, identification, busy, and erase-paused. A parameterised countdown stands in for the duration of each embedded operation. Reads are not decoded as commands. The block reports whether a read at the current address may be served from the array, and it supplies the identification byte while identification mode is active.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_busy, mode_susp and mode_autosel are 0, no strobe is high, and array_rd_ok is 1.
- R2: A write is taken when the combined enable (wr_en_n low and chip_sel_n low) goes inactive. The address is sampled in the first clock it is active and the data in the last. Any strobe appears in the clock after the first clock edge that sees the enables released.
- R3: The writes AAh@555h, 55h@2AAh, A0h@555h followed by any byte D at any address A give one-cycle prog_stb with prog_addr=A and prog_data=D. mode_busy then stays high for PROG_CYC clocks.
- R4: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h give one-cycle chip_erase_stb. mode_busy then stays high for CHIP_CYC clocks.
- R5: The same first five writes followed by 30h at any address give one-cycle sect_erase_stb. erase_sect carries address bits [18:16], and busy lasts SECT_CYC clocks in total.
- R6: The unlock addresses 555h and 2AAh are compared on bits [15:0] only; bits [18:16] are ignored.
- R7: A write whose address or data does not match the next expected step aborts the sequence. No strobe follows, and the next write is decoded as a first step.
- R8: A write of F0h at any address ends any partial sequence and leaves identification mode.
- R9: AAh@555h, 55h@2AAh, 90h@555h sets mode_autosel. While it is set, id_data returns MFR_CODE for bus_addr[7:0]=00h, DEV_CODE for 01h and 00h otherwise, and array_rd_ok is 0.
- R10: While busy, every write is ignored except the suspend of R11. No extra strobe occurs and the busy time is unchanged.
- R11: B0h at any address during a sector erase gives suspend_stb and sets mode_susp with mode_busy low. B0h at any other time has no effect.
- R12: 30h at any address while suspended and idle gives resume_stb and clears mode_susp. The erase then continues for the remaining clocks, so the busy clocks before and after the pause add up to SECT_CYC. 30h outside the suspended state as a first write does nothing.
- R13: While suspended, program sequences are accepted. When the program completes, mode_susp is still 1 and mode_busy is 0. Erase sequences are rejected. array_rd_ok is 0 for addresses in the paused sector and 1 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_n | input | 1 | Active-low write enable |
| chip_sel_n | input | 1 | Active-low chip select |
| bus_addr | input | 19 | Byte address |
| bus_wdata | input | 8 | Write data byte |
| prog_stb | output | 1 | Program accepted pulse |
| prog_addr | output | 19 | Address of last accepted program |
| prog_data | output | 8 | Data of last accepted program |
| chip_erase_stb | output | 1 | Chip erase accepted pulse |
| sect_erase_stb | output | 1 | Sector erase accepted pulse |
| erase_sect | output | 3 | Sector of last sector erase |
| suspend_stb | output | 1 | Erase paused pulse |
| resume_stb | output | 1 | Erase restarted pulse |
| mode_busy | output | 1 | Embedded operation running |
| mode_susp | output | 1 | Sector erase paused |
| mode_autosel | output | 1 | Identification mode |
| array_rd_ok | output | 1 | A read at bus_addr may come from the array |
| id_data | output | 8 | Identification byte for bus_addr |

## Verification
The assertions assume a clean bus. The enables never glitch. Each write holds the combined enable active for at least one clock and releases it for at least one clock before the next write. The stimulus meets this by building every write from a task that asserts the enables for whole clocks and then idles. A suspend is never issued in the same clock in which the erase countdown expires. The stimulus places each pause well inside the erase window, so an erase never finishes and pauses at once.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_PROG,
    OP_SECT,
    OP_CHIP
  } op_e;

  typedef enum logic [2:0] {
    SQ_START,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PDATA,
    SQ_ERA3,
    SQ_ERA4,
    SQ_ERA5
  } seq_e;

  localparam logic [7:0] CMD_UNL_A = 8'hAA;
  localparam logic [7:0] CMD_UNL_B = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_ID    = 8'h90;

  localparam logic [31:0] UNL_ADDR_A = 32'h0000_0555;
  localparam logic [31:0] UNL_ADDR_B = 32'h0000_02AA;

  // low address field compare, caller zero-extends the field
  function automatic logic addr_is(input logic [31:0] low, input logic [31:0] want);
    return low == want;
  endfunction

  // identification byte for an offset
  function automatic logic [7:0] id_byte(input logic [7:0] ofs, input logic [7:0] mfr,
                                         input logic [7:0] dev);
    if (ofs == 8'h00) return mfr;
    if (ofs == 8'h01) return dev;
    return 8'h00;
  endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              chip_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic act, act_q;

  assign act = ~wr_en_n & ~chip_sel_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) wr_addr <= bus_addr;
      if (act)           wr_data <= bus_wdata;
    end
  end

  assign wr_evt = act_q & ~act;
endmodule

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done = run && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int SECT_W   = 3,
  parameter int PROG_CYC = 16,
  parameter int SECT_CYC = 48,
  parameter int CHIP_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_stb,
  output logic              sect_stb,
  output logic [SECT_W-1:0] erase_sect,
  output logic              susp_stb,
  output logic              res_stb,
  output logic              busy,
  output logic              susp,
  output logic              autosel
);
  localparam int LOW_W = ADDR_W - SECT_W;
  localparam int MAX_E = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int MAX_C = (MAX_E > PROG_CYC) ? MAX_E : PROG_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  op_e  op_q, op_n;
  seq_e seq_q, seq_n;
  logic susp_q, susp_n, auto_q, auto_n;
  logic [SECT_W-1:0] esect_q, esect_n;
  logic [ADDR_W-1:0] paddr_q, paddr_n;
  logic [DATA_W-1:0] pdata_q, pdata_n;
  logic prog_p, chip_p, sect_p, susp_p, res_p;
  logic prog_load, era_load, prog_done, era_done;
  logic [CNT_W-1:0] era_val;
  logic at_a, at_b;

  assign at_a = addr_is(32'(wr_addr[LOW_W-1:0]), UNL_ADDR_A);
  assign at_b = addr_is(32'(wr_addr[LOW_W-1:0]), UNL_ADDR_B);

  fcd_busy_timer #(.CNT_W(CNT_W)) u_prog_tmr (
    .clk(clk), .rst_n(rst_n), .load(prog_load), .load_val(CNT_W'(PROG_CYC)),
    .run(op_q == OP_PROG), .done(prog_done)
  );

  fcd_busy_timer #(.CNT_W(CNT_W)) u_era_tmr (
    .clk(clk), .rst_n(rst_n), .load(era_load), .load_val(era_val),
    .run(op_q == OP_SECT || op_q == OP_CHIP), .done(era_done)
  );

  always_comb begin
    op_n = op_q; seq_n = seq_q; susp_n = susp_q; auto_n = auto_q;
    esect_n = esect_q; paddr_n = paddr_q; pdata_n = pdata_q;
    prog_p = 1'b0; chip_p = 1'b0; sect_p = 1'b0; susp_p = 1'b0; res_p = 1'b0;
    prog_load = 1'b0; era_load = 1'b0; era_val = CNT_W'(SECT_CYC);
    unique case (op_q)
      OP_PROG: if (prog_done) op_n = OP_IDLE;
      OP_CHIP: if (era_done) op_n = OP_IDLE;
      OP_SECT: begin
        if (era_done) op_n = OP_IDLE;
        else if (wr_evt && wr_data == CMD_SUSP) begin
          op_n = OP_IDLE; susp_n = 1'b1; susp_p = 1'b1;
        end
      end
      default: if (wr_evt) begin
        seq_n  = SQ_START;
        auto_n = 1'b0;
        unique case (seq_q)
          SQ_START: begin
            if (susp_q && wr_data == CMD_SECT) begin
              op_n = OP_SECT; susp_n = 1'b0; res_p = 1'b1;
            end else if (at_a && wr_data == CMD_UNL_A) begin
              seq_n = SQ_UNL1; auto_n = auto_q;
            end
          end
          SQ_UNL1: if (at_b && wr_data == CMD_UNL_B) begin
            seq_n = SQ_UNL2; auto_n = auto_q;
          end
          SQ_UNL2: if (at_a) begin
            if (wr_data == CMD_PROG) begin
              seq_n = SQ_PDATA; auto_n = auto_q;
            end else if (wr_data == CMD_ID) begin
              auto_n = 1'b1;
            end else if (wr_data == CMD_ERASE && !susp_q) begin
              seq_n = SQ_ERA3; auto_n = auto_q;
            end
          end
          SQ_PDATA: begin
            prog_p = 1'b1; prog_load = 1'b1; op_n = OP_PROG;
            paddr_n = wr_addr; pdata_n = wr_data;
          end
          SQ_ERA3: if (at_a && wr_data == CMD_UNL_A) begin
            seq_n = SQ_ERA4; auto_n = auto_q;
          end
          SQ_ERA4: if (at_b && wr_data == CMD_UNL_B) begin
            seq_n = SQ_ERA5; auto_n = auto_q;
          end
          SQ_ERA5: begin
            if (at_a && wr_data == CMD_CHIP) begin
              chip_p = 1'b1; era_load = 1'b1; era_val = CNT_W'(CHIP_CYC); op_n = OP_CHIP;
            end else if (wr_data == CMD_SECT) begin
              sect_p = 1'b1; era_load = 1'b1; op_n = OP_SECT;
              esect_n = wr_addr[ADDR_W-1 -: SECT_W];
            end
          end
          default: seq_n = SQ_START;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= OP_IDLE; seq_q <= SQ_START; susp_q <= 1'b0; auto_q <= 1'b0;
      esect_q <= '0; paddr_q <= '0; pdata_q <= '0;
      prog_stb <= 1'b0; chip_stb <= 1'b0; sect_stb <= 1'b0;
      susp_stb <= 1'b0; res_stb <= 1'b0;
    end else begin
      op_q <= op_n; seq_q <= seq_n; susp_q <= susp_n; auto_q <= auto_n;
      esect_q <= esect_n; paddr_q <= paddr_n; pdata_q <= pdata_n;
      prog_stb <= prog_p; chip_stb <= chip_p; sect_stb <= sect_p;
      susp_stb <= susp_p; res_stb <= res_p;
    end
  end

  assign prog_addr  = paddr_q;
  assign prog_data  = pdata_q;
  assign erase_sect = esect_q;
  assign busy       = op_q != OP_IDLE;
  assign susp       = susp_q;
  assign autosel    = auto_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         ADDR_W   = 19,
  parameter int         DATA_W   = 8,
  parameter int         SECT_W   = 3,
  parameter int         PROG_CYC = 16,
  parameter int         SECT_CYC = 48,
  parameter int         CHIP_CYC = 64,
  parameter logic [7:0] MFR_CODE = 8'h3C,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              chip_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              prog_stb,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_stb,
  output logic              sect_erase_stb,
  output logic [SECT_W-1:0] erase_sect,
  output logic              suspend_stb,
  output logic              resume_stb,
  output logic              mode_busy,
  output logic              mode_susp,
  output logic              mode_autosel,
  output logic              array_rd_ok,
  output logic [7:0]        id_data
);
  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rd_in_paused;

  fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .chip_sel_n(chip_sel_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_stb(chip_erase_stb), .sect_stb(sect_erase_stb), .erase_sect(erase_sect),
    .susp_stb(suspend_stb), .res_stb(resume_stb),
    .busy(mode_busy), .susp(mode_susp), .autosel(mode_autosel)
  );

  assign rd_in_paused = mode_susp && (bus_addr[ADDR_W-1 -: SECT_W] == erase_sect);
  assign array_rd_ok  = !mode_busy && !mode_autosel && !rd_in_paused;
  assign id_data      = mode_autosel ? fcd_pkg::id_byte(bus_addr[7:0], MFR_CODE, DEV_CODE)
                                     : 8'h00;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_evt,
  input logic prog_stb,
  input logic chip_erase_stb,
  input logic sect_erase_stb,
  input logic suspend_stb,
  input logic resume_stb,
  input logic mode_busy,
  input logic mode_susp,
  input logic mode_autosel
);
  // R3
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

  // R2
  stb_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || chip_erase_stb || sect_erase_stb || suspend_stb || resume_stb) |-> $past(wr_evt));

  // R10
  one_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb}) <= 1);

  // R9
  autosel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_autosel |-> !mode_busy);

  // R11
  susp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_stb |-> (mode_susp && !mode_busy));

  // R12
  resume_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |-> (mode_busy && !mode_susp));

  // R5
  sect_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_stb |-> (mode_busy && !mode_susp));

  // R4
  chip_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_stb |-> (mode_busy && !mode_susp));
endmodule

bind flash_cmd_decoder fcd_checker u_fcd_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt),
  .prog_stb(prog_stb), .chip_erase_stb(chip_erase_stb), .sect_erase_stb(sect_erase_stb),
  .suspend_stb(suspend_stb), .resume_stb(resume_stb),
  .mode_busy(mode_busy), .mode_susp(mode_susp), .mode_autosel(mode_autosel)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int PROG_N = 16;
  localparam int SECT_N = 48;
  localparam int CHIP_N = 64;
  localparam logic [7:0] MFR = 8'h3C;
  localparam logic [7:0] DEV = 8'hD5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en_n = 1'b1, chip_sel_n = 1'b1;
  logic [18:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic prog_stb, chip_erase_stb, sect_erase_stb, suspend_stb, resume_stb;
  logic [18:0] prog_addr;
  logic [7:0] prog_data, id_data;
  logic [2:0] erase_sect;
  logic mode_busy, mode_susp, mode_autosel, array_rd_ok;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.PROG_CYC(PROG_N), .SECT_CYC(SECT_N), .CHIP_CYC(CHIP_N),
                      .MFR_CODE(MFR), .DEV_CODE(DEV)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .chip_sel_n(chip_sel_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .prog_stb(prog_stb), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_stb(chip_erase_stb), .sect_erase_stb(sect_erase_stb), .erase_sect(erase_sect),
    .suspend_stb(suspend_stb), .resume_stb(resume_stb),
    .mode_busy(mode_busy), .mode_susp(mode_susp), .mode_autosel(mode_autosel),
    .array_rd_ok(array_rd_ok), .id_data(id_data)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  int cnt_prog = 0, cnt_chip = 0, cnt_sect = 0, cnt_susp = 0, cnt_res = 0, bcnt = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   m_act_q;
  int   m_addr, m_data;
  byte unsigned m_hist[$];
  int   m_kind;            // 0 idle, 1 program, 2 sector erase, 3 chip erase
  int   m_pleft, m_eleft;
  bit   m_susp, m_auto;
  int   m_esect, m_paddr, m_pdata;
  bit   e_prog, e_chip, e_sect, e_susp, e_res;

  task automatic m_abort();
    m_hist.delete();
    m_auto = 0;
  endtask

  task automatic m_command();
    int lo;
    int step;
    lo = m_addr % 65536;
    step = m_hist.size();
    if (step == 0 && m_susp && m_data == 8'h30) begin
      m_susp = 0; m_kind = 2; e_res = 1; m_auto = 0;
    end else if (step == 0 || step == 3) begin
      if (step == 3 && m_hist[2] == 8'hA0) begin
        m_kind = 1; m_pleft = PROG_N; e_prog = 1;
        m_paddr = m_addr; m_pdata = m_data; m_abort();
      end else if (lo == 'h555 && m_data == 8'hAA) m_hist.push_back(8'hAA);
      else m_abort();
    end else if (step == 1 || step == 4) begin
      if (lo == 'h2AA && m_data == 8'h55) m_hist.push_back(8'h55);
      else m_abort();
    end else if (step == 2) begin
      if (lo == 'h555 && m_data == 8'hA0) m_hist.push_back(8'hA0);
      else if (lo == 'h555 && m_data == 8'h80 && !m_susp) m_hist.push_back(8'h80);
      else if (lo == 'h555 && m_data == 8'h90) begin m_hist.delete(); m_auto = 1; end
      else m_abort();
    end else begin
      if (lo == 'h555 && m_data == 8'h10) begin
        m_kind = 3; m_eleft = CHIP_N; e_chip = 1;
      end else if (m_data == 8'h30) begin
        m_kind = 2; m_eleft = SECT_N; e_sect = 1; m_esect = m_addr / 65536;
      end
      m_abort();
    end
  endtask

  always @(posedge clk) begin
    bit act, evt;
    if (!rst_n) begin
      m_act_q = 0; m_addr = 0; m_data = 0; m_hist.delete(); m_kind = 0;
      m_pleft = 0; m_eleft = 0; m_susp = 0; m_auto = 0; m_esect = 0;
      m_paddr = 0; m_pdata = 0; e_prog = 0; e_chip = 0; e_sect = 0; e_susp = 0; e_res = 0;
    end else begin
      act = !wr_en_n && !chip_sel_n;
      evt = m_act_q && !act;
      if (act && !m_act_q) m_addr = int'(bus_addr);
      if (act) m_data = int'(bus_wdata);
      m_act_q = act;
      e_prog = 0; e_chip = 0; e_sect = 0; e_susp = 0; e_res = 0;
      if (m_kind == 1) begin
        m_pleft--;
        if (m_pleft == 0) m_kind = 0;
      end else if (m_kind != 0) begin
        m_eleft--;
        if (m_eleft == 0) m_kind = 0;
        else if (evt && m_kind == 2 && m_data == 8'hB0) begin
          m_kind = 0; m_susp = 1; e_susp = 1;
        end
      end else if (evt) m_command();
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    int exp_ok, exp_id, ofs;
    if (rst_n) begin
      check("R3 prog_stb", prog_stb, e_prog);
      check("R3 prog_addr", prog_addr, m_paddr);
      check("R3 prog_data", prog_data, m_pdata);
      check("R4 chip_erase_stb", chip_erase_stb, e_chip);
      check("R5 sect_erase_stb", sect_erase_stb, e_sect);
      check("R5 erase_sect", erase_sect, m_esect);
      check("R11 suspend_stb", suspend_stb, e_susp);
      check("R12 resume_stb", resume_stb, e_res);
      check("R10 mode_busy", mode_busy, m_kind != 0);
      check("R13 mode_susp", mode_susp, m_susp);
      check("R9 mode_autosel", mode_autosel, m_auto);
      exp_ok = (m_kind == 0) && !m_auto && !(m_susp && (int'(bus_addr) / 65536) == m_esect);
      check("R13 array_rd_ok", array_rd_ok, exp_ok);
      ofs = int'(bus_addr) % 256;
      exp_id = !m_auto ? 0 : (ofs == 0) ? MFR : (ofs == 1) ? DEV : 0;
      check("R9 id_data", id_data, exp_id);
      if (prog_stb) cnt_prog++;
      if (chip_erase_stb) cnt_chip++;
      if (sect_erase_stb) cnt_sect++;
      if (suspend_stb) cnt_susp++;
      if (resume_stb) cnt_res++;
      if (mode_busy) bcnt++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en_n = 0; chip_sel_n = 0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    wr_en_n = 1; chip_sel_n = 1;
    @(posedge clk); #1;
  endtask

  // select first, address changes mid-write, data changes mid-write
  task automatic wr_split(input logic [18:0] a, input logic [18:0] junk_a, input logic [7:0] d);
    @(posedge clk); #1; chip_sel_n = 0;
    @(posedge clk); #1; wr_en_n = 0; bus_addr = a; bus_wdata = 8'h11;
    @(posedge clk); #1; bus_addr = junk_a; bus_wdata = d;
    @(posedge clk); #1; wr_en_n = 1;
    @(posedge clk); #1; chip_sel_n = 1;
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic wait_idle();
    while (mode_busy) begin @(posedge clk); #1; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    int base, ebusy;
    idle(4);
    rst_n = 1;
    idle(2);
    // R1
    check("R1 busy", mode_busy, 0);
    check("R1 susp", mode_susp, 0);
    check("R1 autosel", mode_autosel, 0);
    check("R1 array_rd_ok", array_rd_ok, 1);
    check("R1 strobe", prog_stb | chip_erase_stb | sect_erase_stb | suspend_stb | resume_stb, 0);

    // R3 program
    unlock(); wr(19'h00555, 8'hA0);
    wr(19'h12345, 8'h5A);
    check("R3 strobe", prog_stb, 1);
    check("R3 addr", prog_addr, 19'h12345);
    check("R3 data", prog_data, 8'h5A);
    bcnt = 0; wait_idle();
    check("R3 busy clocks", bcnt, PROG_N);

    // R6 high bits ignored on unlock
    wr(19'h70555, 8'hAA); wr(19'h702AA, 8'h55); wr(19'h50555, 8'hA0);
    wr(19'h00077, 8'hC3);
    check("R6 strobe", prog_stb, 1);
    check("R6 data", prog_data, 8'hC3);
    wait_idle();

    // R2 address from first active clock, data from last
    unlock(); wr(19'h00555, 8'hA0);
    wr_split(19'h04444, 19'h01111, 8'h99);
    check("R2 addr", prog_addr, 19'h04444);
    check("R2 data", prog_data, 8'h99);
    wait_idle();

    // R7 wrong order and wrong address
    base = cnt_prog;
    unlock(); wr(19'h00555, 8'hAA); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h42);
    wr(19'h00555, 8'hAA); wr(19'h002AB, 8'h55); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h42);
    idle(2);
    check("R7 no program", cnt_prog, base);
    check("R7 not busy", mode_busy, 0);

    // R8 reset mid-sequence
    unlock(); wr(19'h01234, 8'hF0); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h42);
    idle(2);
    check("R8 no program", cnt_prog, base);

    // R9 identification
    unlock(); wr(19'h00555, 8'h90);
    check("R9 autosel", mode_autosel, 1);
    bus_addr = 19'h00000; #1;
    check("R9 mfr", id_data, MFR);
    check("R9 no array", array_rd_ok, 0);
    bus_addr = 19'h00001; #1;
    check("R9 dev", id_data, DEV);
    bus_addr = 19'h00002; #1;
    check("R9 other", id_data, 0);
    wr(19'h00000, 8'hF0);
    check("R8 exit autosel", mode_autosel, 0);
    check("R8 array", array_rd_ok, 1);

    // R4 chip erase
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
    check("R4 strobe", chip_erase_stb, 1);
    bcnt = 0; wait_idle();
    check("R4 busy clocks", bcnt, CHIP_N);

    // R11 / R12 no effect outside their states
    base = cnt_susp;
    wr(19'h00000, 8'hB0); wr(19'h00000, 8'h30); idle(2);
    check("R11 no suspend in read", cnt_susp, base);
    check("R12 no resume in read", cnt_res, 0);
    check("R12 not busy", mode_busy, 0);

    // R10 writes ignored while busy
    base = cnt_prog;
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00200, 8'h01);
    bcnt = 0;
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00300, 8'h02); wr(19'h00000, 8'hB0);
    wait_idle();
    check("R10 one program", cnt_prog, base + 1);
    check("R10 busy clocks", bcnt, PROG_N);
    check("R11 no suspend in program", cnt_susp, 0);
    check("R10 data kept", prog_data, 8'h01);

    // R5 sector erase then R11 suspend
    unlock(); wr(19'h00555, 8'h80); unlock();
    wr(19'h51234, 8'h30);
    check("R5 strobe", sect_erase_stb, 1);
    check("R5 sector", erase_sect, 5);
    bcnt = 0;
    idle(5);
    wr(19'h00000, 8'hB0);
    ebusy = bcnt;
    check("R11 strobe", suspend_stb, 1);
    check("R11 susp", mode_susp, 1);
    check("R11 idle", mode_busy, 0);

    // R13 reads, program and rejected erase while paused
    bus_addr = 19'h50000; #1;
    check("R13 paused sector", array_rd_ok, 0);
    bus_addr = 19'h20000; #1;
    check("R13 other sector", array_rd_ok, 1);
    base = cnt_prog;
    unlock(); wr(19'h00555, 8'hA0); wr(19'h20010, 8'h66);
    check("R13 program strobe", prog_stb, 1);
    wait_idle();
    check("R13 back to paused", mode_susp, 1);
    check("R13 busy off", mode_busy, 0);
    base = cnt_chip;
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10); idle(2);
    check("R13 erase rejected", cnt_chip, base);
    check("R13 still paused", mode_susp, 1);

    // R12 resume finishes the remaining clocks
    bcnt = 0;
    wr(19'h00000, 8'h30);
    check("R12 strobe", resume_stb, 1);
    check("R12 busy", mode_busy, 1);
    check("R12 susp cleared", mode_susp, 0);
    wait_idle();
    check("R12 total erase clocks", ebusy + bcnt, SECT_N);

    idle(3);
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule